// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock, taken from a VCO through an input stage, down to a low-rate feedback pulse for a phase detector. It models a dual-modulus prescaler that divides by 2^PSC_W or by 2^PSC_W+1 (64 or 65 with the default width). A swallow counter picks the modulus and a main counter counts prescaler periods. For a main value N and a swallow value A, each feedback cycle spans N·2^PSC_W + A input clocks and ends with a single one-clock high pulse on `fv_o`. The current prescaler modulus is also brought out, as `modsel_o`.

N, A and a two-bit output select come from a configuration register that is written with a load strobe. The new N and A are held back until the current division cycle has ended, so a reload never produces a short or long feedback pulse. A shared output pin carries one of three sources: the feedback pulse, so the loop can be observed; a serial data bit from a companion shift register, which that register updates on the falling edge of its shift clock; or a static port bit. After reset the pin carries the serial data, so that several parts can be chained.

Top module: `pswallow_div`

## Requirements
- R1: With effective values N and A, consecutive `fv_o` pulses are exactly N·2^PSC_W + A input clocks apart.
- R2: `fv_o` is low except for single-clock high pulses, one per division cycle.
- R3: Within a cycle, `modsel_o` is high (prescaler period of 2^PSC_W+1 clocks) for the first A prescaler periods and low (period of 2^PSC_W clocks) for the remaining N−A periods, so it is high for A·(2^PSC_W+1) clocks per cycle. It rises only at a cycle start.
- R4: A loaded N of 0 is used as 1. A loaded A greater than the effective N is used as that N.
- R5: A load (`cfg_load_i` high at a clock edge) leaves the cycle in progress at its old ratio. The next cycle uses the new N and A.
- R6: Select code 2'b10 routes `fv_o` to `shared_o`.
- R7: Select code 2'b01 routes `ser_i` to `shared_o`. Reset sets the select to 2'b01.
- R8: Select codes 2'b00 and 2'b11 route `port_i` to `shared_o`.
- R9: During and right after reset, `fv_o` is low. The values on `cfg_n_i` and `cfg_a_i` while reset is high become the ratio of the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_load_i | input | 1 | Captures N, A and the select at this edge |
| cfg_n_i | input | N_W | Main counter value N |
| cfg_a_i | input | PSC_W | Swallow counter value A |
| cfg_sel_i | input | 2 | Shared pin source select |
| ser_i | input | 1 | Serial data bit from the shift register |
| port_i | input | 1 | Static port bit |
| fv_o | output | 1 | Divided feedback pulse |
| modsel_o | output | 1 | Prescaler modulus control, high = divide by 2^PSC_W+1 |
| shared_o | output | 1 | Shared output pin |

## Verification
The bench runs with a 4/5 prescaler and a 4-bit N, and sweeps every N and A pairing. This covers N = 0, A = 0, A = N and A > N. Each case separates the 4·N + A ratio from near misses such as 5·A + 4·N or a lost swallow period, and the count of clocks with `modsel_o` high is checked against A·5. A reload made in the middle of a cycle shows whether the running cycle keeps its length and the next one takes the new ratio. All four select codes are driven with every combination of serial and port levels.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    typedef enum logic [1:0] {
        OSEL_PORT  = 2'b00,
        OSEL_SER   = 2'b01,
        OSEL_FV    = 2'b10,
        OSEL_PORTX = 2'b11
    } osel_e;

    localparam logic [1:0] OSEL_RESET = 2'b01;

endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           cfg_load_i,
    input  logic [N_W-1:0] cfg_n_i,
    input  logic [A_W-1:0] cfg_a_i,
    input  logic [1:0]     cfg_sel_i,
    output logic [N_W-1:0] n_next_o,
    output logic [A_W-1:0] a_next_o,
    output logic [1:0]     osel_o
);
    import pswallow_pkg::*;

    typedef struct packed {
        logic [N_W-1:0] n_pend;
        logic [A_W-1:0] a_pend;
        logic [1:0]     osel;
    } cfg_t;

    cfg_t           st_d, st_q;
    logic [N_W-1:0] n_eff;
    logic [N_W-1:0] a_ext;
    logic [A_W-1:0] a_eff;
    logic           take_new;

    always_comb begin
        n_eff = (cfg_n_i == '0) ? N_W'(1) : cfg_n_i;
        a_ext = N_W'(cfg_a_i);
        a_eff = (a_ext > n_eff) ? A_W'(n_eff) : cfg_a_i;
        take_new = rst_i | cfg_load_i;

        st_d = st_q;
        if (rst_i) begin
            st_d.n_pend = n_eff;
            st_d.a_pend = a_eff;
            st_d.osel   = OSEL_RESET;
        end else if (cfg_load_i) begin
            st_d.n_pend = n_eff;
            st_d.a_pend = a_eff;
            st_d.osel   = cfg_sel_i;
        end

        n_next_o = take_new ? n_eff : st_q.n_pend;
        a_next_o = take_new ? a_eff : st_q.a_pend;
        osel_o   = st_q.osel;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/pswallow_psc.sv
module pswallow_psc #(
    parameter int PSC_W = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic swallow_i,
    output logic end_o
);
    localparam int          PC_W   = PSC_W + 1;
    localparam int          P      = 1 << PSC_W;
    localparam logic [PC_W-1:0] LIM_LO = PC_W'(P - 1);
    localparam logic [PC_W-1:0] LIM_HI = PC_W'(P);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } psc_t;

    psc_t st_d, st_q;
    logic at_end;

    always_comb begin
        at_end = (st_q.cnt == (swallow_i ? LIM_HI : LIM_LO));
        st_d   = st_q;
        if (rst_i || at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PC_W'(1);
        end
        end_o = at_end & ~rst_i;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/pswallow_cnt.sv
module pswallow_cnt #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           psc_end_i,
    input  logic [N_W-1:0] n_next_i,
    input  logic [A_W-1:0] a_next_i,
    output logic           swallow_o,
    output logic           fv_o
);
    typedef struct packed {
        logic [N_W-1:0] n_rem;
        logic [A_W-1:0] a_rem;
        logic           fv;
    } cnt_t;

    cnt_t st_d, st_q;
    logic cyc_end;

    always_comb begin
        cyc_end = psc_end_i && (st_q.n_rem == N_W'(1));
        st_d    = st_q;
        st_d.fv = 1'b0;
        if (rst_i) begin
            st_d.n_rem = n_next_i;
            st_d.a_rem = a_next_i;
        end else if (cyc_end) begin
            st_d.n_rem = n_next_i;
            st_d.a_rem = a_next_i;
            st_d.fv    = 1'b1;
        end else if (psc_end_i) begin
            st_d.n_rem = st_q.n_rem - N_W'(1);
            if (st_q.a_rem != '0) begin
                st_d.a_rem = st_q.a_rem - A_W'(1);
            end
        end
        swallow_o = (st_q.a_rem != '0);
        fv_o      = st_q.fv;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/pswallow_osel.sv
module pswallow_osel (
    input  logic [1:0] osel_i,
    input  logic       fv_i,
    input  logic       ser_i,
    input  logic       port_i,
    output logic       pin_o
);
    import pswallow_pkg::*;

    always_comb begin
        unique case (osel_e'(osel_i))
            OSEL_FV:  pin_o = fv_i;
            OSEL_SER: pin_o = ser_i;
            default:  pin_o = port_i;
        endcase
    end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
    parameter int PSC_W = 6,
    parameter int N_W   = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_load_i,
    input  logic [N_W-1:0]   cfg_n_i,
    input  logic [PSC_W-1:0] cfg_a_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic             ser_i,
    input  logic             port_i,
    output logic             fv_o,
    output logic             modsel_o,
    output logic             shared_o
);
    localparam int A_W = PSC_W;

    logic [N_W-1:0] n_next;
    logic [A_W-1:0] a_next;
    logic [1:0]     osel;
    logic           psc_end;
    logic           swallow;
    logic           fv;

    pswallow_cfg #(.N_W(N_W), .A_W(A_W)) u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cfg_load_i (cfg_load_i),
        .cfg_n_i    (cfg_n_i),
        .cfg_a_i    (cfg_a_i),
        .cfg_sel_i  (cfg_sel_i),
        .n_next_o   (n_next),
        .a_next_o   (a_next),
        .osel_o     (osel)
    );

    pswallow_psc #(.PSC_W(PSC_W)) u_psc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .swallow_i (swallow),
        .end_o     (psc_end)
    );

    pswallow_cnt #(.N_W(N_W), .A_W(A_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .psc_end_i (psc_end),
        .n_next_i  (n_next),
        .a_next_i  (a_next),
        .swallow_o (swallow),
        .fv_o      (fv)
    );

    pswallow_osel u_osel (
        .osel_i (osel),
        .fv_i   (fv),
        .ser_i  (ser_i),
        .port_i (port_i),
        .pin_o  (shared_o)
    );

    assign fv_o     = fv;
    assign modsel_o = swallow;

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
    parameter int N_W = 12,
    parameter int A_W = 6
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           fv_o,
    input logic           modsel_o,
    input logic           shared_o,
    input logic           ser_i,
    input logic           port_i,
    input logic [1:0]     osel,
    input logic           psc_end,
    input logic [N_W-1:0] n_next,
    input logic [A_W-1:0] a_next
);
    AST_FV_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        fv_o |=> !fv_o); // R2

    AST_MODSEL_RISE_AT_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(modsel_o) |-> fv_o); // R3

    AST_MODSEL_HOLD_IN_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        !psc_end |=> $stable(modsel_o)); // R3

    AST_EFF_VALUES: assert property (@(posedge clk_i) disable iff (rst_i)
        (n_next != '0) && (N_W'(a_next) <= n_next)); // R4

    AST_PIN_FV: assert property (@(posedge clk_i) disable iff (rst_i)
        (osel == 2'b10) |-> (shared_o == fv_o)); // R6

    AST_SEL_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (osel == 2'b01) && (shared_o == ser_i)); // R7

    AST_PIN_PORT: assert property (@(posedge clk_i) disable iff (rst_i)
        ((osel == 2'b00) || (osel == 2'b11)) |-> (shared_o == port_i)); // R8

    AST_FV_LOW_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !fv_o); // R9

endmodule

bind pswallow_div pswallow_div_chk #(.N_W(N_W), .A_W(A_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .fv_o     (fv_o),
    .modsel_o (modsel_o),
    .shared_o (shared_o),
    .ser_i    (ser_i),
    .port_i   (port_i),
    .osel     (osel),
    .psc_end  (psc_end),
    .n_next   (n_next),
    .a_next   (a_next)
);

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
    localparam int PSC_W = 2;
    localparam int N_W   = 4;
    localparam int P     = 1 << PSC_W;

    logic             clk = 1'b0;
    logic             rst_i = 1'b1;
    logic             cfg_load_i = 1'b0;
    logic [N_W-1:0]   cfg_n_i = '0;
    logic [PSC_W-1:0] cfg_a_i = '0;
    logic [1:0]       cfg_sel_i = 2'b00;
    logic             ser_i = 1'b0;
    logic             port_i = 1'b0;
    logic             fv_o, modsel_o, shared_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pswallow_div #(.PSC_W(PSC_W), .N_W(N_W)) u_dut (
        .clk_i(clk), .rst_i(rst_i), .cfg_load_i(cfg_load_i),
        .cfg_n_i(cfg_n_i), .cfg_a_i(cfg_a_i), .cfg_sel_i(cfg_sel_i),
        .ser_i(ser_i), .port_i(port_i),
        .fv_o(fv_o), .modsel_o(modsel_o), .shared_o(shared_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_eff(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int a_eff(input int n, input int a);
        return (a > n_eff(n)) ? n_eff(n) : a;
    endfunction

    task automatic do_reset(input int n, input int a);
        @(negedge clk);
        rst_i = 1'b1; cfg_n_i = N_W'(n); cfg_a_i = PSC_W'(a);
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
    endtask

    task automatic wait_fv();
        int guard = 0;
        while (!fv_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic measure(output int per, output int mcc);
        per = 0; mcc = 0;
        wait_fv();
        do begin
            if (modsel_o) mcc++;
            @(negedge clk);
            per++;
        end while (!fv_o && per < 5000);
    endtask

    initial begin
        int per, mcc, hit;
        // R9 and R7: state during and just after reset
        do_reset(5, 1);
        ser_i = 1'b1;
        #1;
        check("R9 fv low after reset", fv_o, 0);
        check("R7 reset select serial", shared_o, 1);
        ser_i = 1'b0;
        #1;
        check("R7 reset select serial low", shared_o, 0);

        // R1 R3 R4: every N and A of the small configuration
        for (int n = 0; n < (1 << N_W); n++) begin
            for (int a = 0; a < P; a++) begin
                do_reset(n, a);
                measure(per, mcc);
                check($sformatf("R1 R4 ratio n=%0d a=%0d", n, a), per,
                      n_eff(n) * P + a_eff(n, a));
                check($sformatf("R3 modsel clocks n=%0d a=%0d", n, a), mcc,
                      a_eff(n, a) * (P + 1));
                measure(per, mcc);
                check($sformatf("R1 second period n=%0d a=%0d", n, a), per,
                      n_eff(n) * P + a_eff(n, a));
            end
        end

        // R2: fv is a single clock wide
        do_reset(3, 2);
        wait_fv();
        @(negedge clk);
        check("R2 fv one clock", fv_o, 0);

        // R5: reload mid-cycle
        do_reset(5, 1);
        wait_fv();
        per = 0;
        do begin
            @(negedge clk);
            per++;
            if (per == 3) begin
                cfg_n_i = 4'd3; cfg_a_i = 2'd2; cfg_sel_i = 2'b01; cfg_load_i = 1'b1;
            end else begin
                cfg_load_i = 1'b0;
            end
        end while (!fv_o && per < 5000);
        check("R5 running cycle keeps old ratio", per, 5 * P + 1);
        measure(per, mcc);
        check("R5 next cycle uses new ratio", per, 3 * P + 2);
        check("R5 new swallow clocks", mcc, 2 * (P + 1));

        // R6 R7 R8: select codes with all serial/port levels
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            cfg_sel_i = 2'(s); cfg_load_i = 1'b1;
            @(negedge clk);
            cfg_load_i = 1'b0;
            for (int v = 0; v < 4; v++) begin
                ser_i = v[0]; port_i = v[1];
                #1;
                if (s == 1) check("R7 select 01 serial", shared_o, v[0]);
                else if (s == 0) check("R8 select 00 port", shared_o, v[1]);
                else if (s == 3) check("R8 select 11 port", shared_o, v[1]);
            end
            if (s == 2) begin
                hit = 0;
                ser_i = 1'b0; port_i = 1'b0;
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (shared_o != fv_o) hit++;
                end
                check("R6 select 10 follows fv", hit, 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule